// File: doc/BRIEF.md
# D-Channel Echo Line Tester

This block works on the terminal side of a basic-rate S/T link, one bit per cycle of a recovered bit clock. A start pulse begins a reduced activation exchange with the network termination. Once the link is up, the block sends full 48-bit terminal-to-network frames. Every D-channel slot carries a 1,0,1,0… pattern that runs on across frame boundaries. The block reads each incoming network-to-terminal frame, takes out the four echo (E) bits, and compares each one with the D bit it sent in the same slot a set number of frames earlier.

The received frame-sync strobe marks bit 0 of an incoming frame. The outgoing frame is aligned to the same position count. A bit counter flywheels through frames that lack the strobe. Three such frames in a row while active drop the link. A mismatch sets a sticky fail flag, and a flash output blinks at a frame-based rate while the flag is set. Line coding, level measurement and clock recovery stay outside this block.

Top module: `dchan_echo_tester`

## Requirements
- R1: After reset, status is 0 (idle), tx_bit is constantly 1, and fail and flash are 0.
- R2: A start pulse moves the block to status 1. From the next frame onward it sends the wake-up frame: bit 0 is 0 and bits 1..47 are 1.
- R3: In status 1, a frame that began with a sync strobe and carries A (received bit 12) = 0 moves the block to status 2 at the next frame start. In status 2, full frames are sent with bit 0 and bit 13 at 0, B bits at 1, D slots 11, 24, 35 and 46 at 1, and each balance bit (1, 10, 12, 14, 23, 25, 34, 36, 45, 47) chosen so its group has even parity.
- R4: In status 2, a synced frame with A = 1 moves the block to status 3 (active) at the next frame start. Status 3 is entered only from status 2.
- R5: If ACT_TIMEOUT frame starts pass in status 1 or 2 without progress, the status becomes 4 and tx_bit returns to constant 1.
- R6: In status 3, the D slots carry an alternating sequence that starts with 1 at the first D slot and continues across frames (1,0,1,0 in slots 11, 24, 35, 46). The balance bit after each D bit equals that D bit.
- R7: In status 3, received E bits at slots 10, 23, 34 and 45 of synced frames are compared with the D bit sent ECHO_FRAMES frames earlier in the matching slot. No comparison is made before that history exists, and a correct echo leaves fail at 0.
- R8: Any echo mismatch sets fail. Fail stays set until the next start pulse, which clears it.
- R9: flash is 0 while fail is 0. While fail is set, flash starts at 0 and toggles at every FLASH_FRAMES-th frame start.
- R10: In status 3, two frames in a row without a sync strobe keep the link active. The third one sets status 5, which stops the pattern (tx_bit constant 1) and the comparison.
- R11: A start pulse restarts activation from any status, including 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin (or restart) the test |
| rx_bit | input | 1 | Received network-to-terminal bit |
| rx_sync | input | 1 | High on bit 0 of a received frame |
| tx_bit | output | 1 | Transmitted terminal-to-network bit for the current position |
| status | output | 3 | 0 idle, 1 wake-up, 2 full frames, 3 active, 4 no activation, 5 sync lost |
| fail | output | 1 | Sticky echo-mismatch flag |
| flash | output | 1 | Blinking indicator while fail is set |

## Verification
A wrong position count or parity bit shows up on tx_bit within the same frame, at a known slot: a missing zero at bit 13 or a balance bit of the wrong sense. A state machine stuck or stepping too early shows up on status and on the frame content one frame after the stimulus. A history register with the wrong depth or tap raises fail on a correctly echoed frame within one frame of reaching active, or misses the single corrupted echo. Errors in the flash counter show up four frames after a mismatch, and errors in the sync-loss count show up on the second or third unsynced frame.

// File: rtl/dchan_echo_tester.sv
module dchan_echo_tester #(
  parameter int ACT_TIMEOUT  = 8,
  parameter int ECHO_FRAMES  = 1,
  parameter int FLASH_FRAMES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rx_bit,
  input  logic       rx_sync,
  output logic       tx_bit,
  output logic [2:0] status,
  output logic       fail,
  output logic       flash
);
  localparam int HIST = 4 * ECHO_FRAMES;
  localparam int TW   = $clog2(ACT_TIMEOUT + 1);
  localparam int HW   = $clog2(HIST + 1);
  localparam int FW   = $clog2(FLASH_FRAMES + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_WAKE = 3'd1, S_FULL = 3'd2,
                         S_ACT  = 3'd3, S_NOACT = 3'd4, S_LOST = 3'd5;

  logic [5:0]      pos_q, pos;
  logic [2:0]      st_q;
  logic            locked, a_valid, a_val, d_ph, par;
  logic [1:0]      miss;
  logic [TW-1:0]   tcnt;
  logic [HIST-1:0] hist;
  logic [HW-1:0]   hcnt;
  logic [FW-1:0]   fcnt;

  assign pos = (rx_sync || pos_q == 6'd47) ? 6'd0 : pos_q + 6'd1;

  wire fs      = (pos == 6'd0);
  wire miss_ev = (pos_q == 6'd47) && !rx_sync;
  wire d_slot  = (pos == 6'd11) || (pos == 6'd24) || (pos == 6'd35) || (pos == 6'd46);
  wire e_slot  = (pos == 6'd10) || (pos == 6'd23) || (pos == 6'd34) || (pos == 6'd45);
  wire l_slot  = (pos == 6'd1)  || (pos == 6'd10) || (pos == 6'd12) || (pos == 6'd14) ||
                 (pos == 6'd23) || (pos == 6'd25) || (pos == 6'd34) || (pos == 6'd36) ||
                 (pos == 6'd45) || (pos == 6'd47);
  wire full    = (st_q == S_FULL) || (st_q == S_ACT);
  wire tmo     = (tcnt == TW'(ACT_TIMEOUT - 1));

  assign status = st_q;

  always_comb begin
    tx_bit = 1'b1;
    if (st_q == S_WAKE)
      tx_bit = (pos != 6'd0);
    else if (full) begin
      if (pos == 6'd0 || pos == 6'd13) tx_bit = 1'b0;
      else if (l_slot)                 tx_bit = par;
      else if (d_slot)                 tx_bit = (st_q == S_ACT) ? d_ph : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= 6'd47;  st_q <= S_IDLE;  locked <= 1'b0;  miss <= 2'd0;
      a_valid <= 1'b0; a_val <= 1'b0;   tcnt <= '0;      d_ph <= 1'b1;
      par <= 1'b0;     hist <= '0;      hcnt <= '0;      fail <= 1'b0;
      flash <= 1'b0;   fcnt <= '0;
    end else begin
      pos_q <= pos;
      par   <= l_slot ? 1'b0 : (fs ? tx_bit : par ^ tx_bit);

      if (rx_sync) begin
        locked <= 1'b1;
        miss   <= 2'd0;
      end else if (miss_ev) begin
        locked <= 1'b0;
        if (miss != 2'd3) miss <= miss + 2'd1;
      end

      if (pos == 6'd12 && locked) begin
        a_valid <= 1'b1;
        a_val   <= rx_bit;
      end else if (fs) a_valid <= 1'b0;

      if (fs) begin
        case (st_q)
          S_WAKE:
            if (a_valid && !a_val) begin st_q <= S_FULL; tcnt <= '0; end
            else if (tmo) st_q <= S_NOACT;
            else tcnt <= tcnt + 1'b1;
          S_FULL:
            if (a_valid && a_val) begin st_q <= S_ACT; d_ph <= 1'b1; hcnt <= '0; end
            else if (tmo) st_q <= S_NOACT;
            else tcnt <= tcnt + 1'b1;
          S_ACT:
            if (miss_ev && miss == 2'd2) st_q <= S_LOST;
          default: ;
        endcase
      end

      if (st_q == S_ACT && d_slot) begin
        hist <= {hist[HIST-2:0], d_ph};
        d_ph <= ~d_ph;
        if (hcnt != HW'(HIST)) hcnt <= hcnt + 1'b1;
      end

      if (st_q == S_ACT && e_slot && locked && hcnt == HW'(HIST) && rx_bit != hist[HIST-1])
        fail <= 1'b1;

      if (!fail) begin
        fcnt  <= '0;
        flash <= 1'b0;
      end else if (fs) begin
        if (fcnt == FW'(FLASH_FRAMES - 1)) begin
          fcnt  <= '0;
          flash <= ~flash;
        end else fcnt <= fcnt + 1'b1;
      end

      if (start) begin
        st_q    <= S_WAKE;
        tcnt    <= '0;
        a_valid <= 1'b0;
        fail    <= 1'b0;
        flash   <= 1'b0;
        fcnt    <= '0;
      end
    end
  end

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) fail && !start |=> fail);
  // R8
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> !fail);
  // R9
  flash_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !fail |-> !flash);
  // R7
  fail_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(fail) |-> $past(st_q) == S_ACT);
  // R4
  act_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != S_ACT |=> (st_q != S_ACT) || ($past(st_q) == S_FULL));
  // R10
  lost_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != S_LOST |=> (st_q != S_LOST) || ($past(st_q) == S_ACT));
  // R5
  tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n) tcnt <= TW'(ACT_TIMEOUT - 1));
endmodule

// File: tb/dchan_echo_tester_tb.sv
module dchan_echo_tester_tb;
  localparam int CLK_P = 10;
  localparam logic [3:0] EOK = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rx_bit = 1'b1, rx_sync = 1'b0;
  logic tx_bit, fail, flash;
  logic [2:0] status;
  int checks = 0, errors = 0;
  logic  exp_q[$];
  string tag_q[$];

  dchan_echo_tester u_dut (.clk(clk), .rst_n(rst_n), .start(start), .rx_bit(rx_bit),
                           .rx_sync(rx_sync), .tx_bit(tx_bit), .status(status),
                           .fail(fail), .flash(flash));

  always #(CLK_P/2) clk = ~clk;

  // mode 0 idle, 1 wake-up frame, 2 full frame D=1, 3 active pattern
  function automatic logic exp_tx(int mode, int p);
    if (mode == 0) return 1'b1;
    if (mode == 1) return p != 0;
    case (p)
      0, 13, 1, 10, 14, 23, 34, 45: return 1'b0;
      11, 12, 35, 36:               return 1'b1;
      24, 25, 46, 47:               return (mode == 3) ? 1'b0 : 1'b1;
      default:                      return 1'b1;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(int mode, bit sync, bit a, logic [3:0] e, bit st_end, string req);
    for (int p = 0; p < 48; p++) begin
      @(posedge clk); #1;
      rx_sync = sync && (p == 0);
      start   = st_end && (p == 47);
      case (p)
        0:       rx_bit = 1'b0;
        12:      rx_bit = a;
        10:      rx_bit = e[0];
        23:      rx_bit = e[1];
        34:      rx_bit = e[2];
        45:      rx_bit = e[3];
        default: rx_bit = 1'b1;
      endcase
      exp_q.push_back(exp_tx(mode, p));
      tag_q.push_back(req);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " tx_bit"}, tx_bit, e);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 status", status, 0);
    check("R1 fail", fail, 0);
    check("R1 flash", flash, 0);
    frame(0, 1, 1, EOK, 0, "R1");
    frame(0, 1, 1, EOK, 1, "R1");
    // timeout: A stays 1, no progress
    for (int i = 1; i <= 8; i++) begin
      frame(1, 1, 1, EOK, 0, "R2/R5");
      if (i == 7) check("R5 status before limit", status, 1);
    end
    check("R5 status", status, 4);
    frame(0, 1, 1, EOK, 1, "R5");
    // activation
    frame(1, 1, 0, EOK, 0, "R2");
    check("R2 status", status, 1);
    frame(2, 1, 1, EOK, 0, "R3");
    check("R3 status", status, 2);
    frame(3, 1, 1, 4'b1010, 0, "R6");
    check("R4 status", status, 3);
    check("R7 no compare in first active frame", fail, 0);
    frame(3, 1, 1, EOK, 0, "R6");
    frame(3, 1, 1, EOK, 0, "R6");
    check("R7 correct echo", fail, 0);
    // two misses tolerated
    frame(3, 0, 1, EOK, 0, "R10");
    frame(3, 0, 1, EOK, 0, "R10");
    frame(3, 1, 1, EOK, 0, "R10");
    check("R10 two misses keep active", status, 3);
    check("R10 fail after resync", fail, 0);
    // three misses drop the link
    frame(3, 0, 1, EOK, 0, "R10");
    frame(3, 0, 1, EOK, 0, "R10");
    frame(1, 0, 1, EOK, 0, "R10");
    check("R10 status lost", status, 5);
    frame(0, 1, 1, 4'b1010, 1, "R10");
    check("R10 no compare when lost", fail, 0);
    // restart from lost, then inject mismatch
    frame(1, 1, 0, EOK, 0, "R11");
    check("R11 restart status", status, 1);
    frame(2, 1, 1, EOK, 0, "R11");
    frame(3, 1, 1, EOK, 0, "R11");
    check("R11 active again", status, 3);
    frame(3, 1, 1, EOK, 0, "R7");
    frame(3, 1, 1, 4'b0111, 0, "R8");
    check("R8 fail set", fail, 1);
    check("R9 flash starts low", flash, 0);
    for (int i = 1; i <= 8; i++) begin
      frame(3, 1, 1, EOK, i == 8, "R9");
      if (i == 3) check("R9 flash before period", flash, 0);
      if (i == 4) check("R9 flash first toggle", flash, 1);
      if (i == 7) check("R9 flash held", flash, 1);
    end
    check("R9 flash second toggle", flash, 0);
    check("R8 fail sticky", fail, 1);
    frame(1, 1, 1, EOK, 0, "R8");
    check("R8 start clears fail", fail, 0);
    check("R9 flash cleared", flash, 0);
    check("R11 status after restart", status, 1);
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule